// File: doc/BRIEF.md
# Exception Priority Resolver

This block chooses which exception a small CPU core services next. Every cycle it looks at requests from four fixed classes: reset sources, one non-maskable external interrupt, eight maskable interrupt channels and three software exceptions (illegal-opcode trap, system call, software interrupt). Reset requests are acted on at once. All other classes are considered only when the core reports an instruction boundary. At that point one winner is chosen, and its vector address is registered together with a one-cycle take strobe.

Each maskable channel carries a programmable 3-bit priority level and a fixed 16-bit vector address from a constant table. A channel competes only while the global interrupt-disable input is low and its level is strictly above the core's current priority level. The highest level wins. Among channels at the same level, the higher vector address wins. The winning channel receives a one-cycle acknowledge, which the source uses to drop an edge-type request. Requests that lose stay asserted by their sources and win in later rounds.

The non-maskable interrupt has its own block bit. The bit is set by reset and can be cleared by a pulse. After that it stays clear until the next reset. The stacking of state, the vector fetch and nesting belong to the core and are not part of this block.

Top module: `exc_arbiter`

## Requirements
- R1: If any bit of `rst_src_i` is high, the next cycle shows `take_o`=1 and `vec_o`=16'hFFFE, whatever `boundary_i` and the other requests are.
- R2: When no reset source is active, a boundary sample with an unblocked non-maskable request yields vector 16'hFFF4, ahead of every maskable and software request.
- R3: The non-maskable block bit is set by `rst` and cleared by a one-cycle `nmi_unblock_i` pulse. Once cleared it stays clear until `rst`. While it is set, `nmi_req_i` has no effect.
- R4: While `imask_i`=1, no maskable channel is taken and no acknowledge is raised.
- R5: Channel i competes only if its level `irq_lvl_i[3i+2:3i]` is strictly greater than `cur_lvl_i`. Level 0 therefore never competes.
- R6: Among the competing channels, the one with the highest level is taken.
- R7: Among competing channels at the same highest level, the one with the higher vector is taken. The vector of channel i is 16'hFF80 + 2*((3*i+5) mod 8).
- R8: Software requests rank lowest. Their vectors are 16'hFFF8 for the trap (`sw_trap_i`), 16'hFFF0 for the system call (`sw_sys_i`) and 16'hFFF6 for the software interrupt (`sw_swi_i`).
- R9: Apart from reset, a request is taken only if `boundary_i` was high at the previous clock edge. With no take, `take_o`=0 and `vec_o` keeps its last value.
- R10: Each take services exactly one exception. `ack_o` is one-hot and appears in the same cycle as `take_o` only when a maskable channel won, so the losing requests are taken in later rounds.
- R11: After `rst`, `take_o`=0, `vec_o`=0 and `ack_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src_i | input | 3 | Reset source requests |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| nmi_unblock_i | input | 1 | Pulse that clears the non-maskable block bit |
| irq_pend_i | input | 8 | Maskable channel pending flags |
| irq_lvl_i | input | 24 | Per-channel priority levels, 3 bits each |
| imask_i | input | 1 | Global maskable interrupt disable |
| cur_lvl_i | input | 3 | Current CPU priority level |
| sw_trap_i | input | 1 | Illegal-opcode trap request |
| sw_sys_i | input | 1 | System call request |
| sw_swi_i | input | 1 | Software interrupt request |
| boundary_i | input | 1 | Instruction boundary, arbitration sample |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | 16 | Vector address of the taken exception |
| ack_o | output | 8 | One-hot acknowledge for the winning maskable channel |

## Verification
The choice is made from the inputs at a clock edge, and `take_o`, `vec_o` and `ack_o` are all due one cycle later. The exception is the block bit for the non-maskable interrupt, which changes at the edge where the unblock pulse is sampled and first affects the following arbitration. The bench changes its inputs shortly after a rising edge. A behavioural model reads the same inputs at that edge, and all three outputs are compared a few nanoseconds after the next edge. The bench's own pending set drops a channel only after it has seen `ack_o`, so requests that lost come back in later rounds.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int VW = 16;

  localparam logic [VW-1:0] VEC_RESET = 16'hFFFE;
  localparam logic [VW-1:0] VEC_NMI   = 16'hFFF4;
  localparam logic [VW-1:0] VEC_TRAP  = 16'hFFF8;
  localparam logic [VW-1:0] VEC_SYS   = 16'hFFF0;
  localparam logic [VW-1:0] VEC_SWI   = 16'hFFF6;
  localparam logic [VW-1:0] IRQ_BASE  = 16'hFF80;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_RST, CLS_NMI, CLS_IRQ, CLS_TRAP, CLS_SYS, CLS_SWI
  } exc_cls_e;

  // Fixed vector slot of a maskable channel; the stride 3 must be coprime
  // to the channel count so that every slot is distinct.
  function automatic logic [VW-1:0] irq_vector(input int idx, input int nch);
    return IRQ_BASE + VW'(2 * ((3 * idx + 5) % nch));
  endfunction
endpackage

// File: rtl/nmi_gate.sv
module nmi_gate (
  input  logic clk,
  input  logic rst,
  input  logic unblock_i,
  input  logic req_i,
  output logic req_o
);
  logic block_q;

  always_ff @(posedge clk) begin
    if (rst)            block_q <= 1'b1;
    else if (unblock_i) block_q <= 1'b0;
  end

  assign req_o = req_i & ~block_q;

  // R3: once unblocked, the block bit never returns before reset
  assert_nmi_block_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !block_q |=> !block_q);
endmodule

// File: rtl/irq_select.sv
module irq_select
  import exc_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int LW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pend_i,
  input  logic [NCH*LW-1:0] lvl_i,
  input  logic              imask_i,
  input  logic [LW-1:0]     cur_lvl_i,
  output logic              valid_o,
  output logic [NCH-1:0]    grant_o,
  output logic [VW-1:0]     vec_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int KW = LW + VW;

  logic [VW-1:0]  vtab [NCH];
  logic [NCH-1:0] elig;
  logic [KW-1:0]  best_key;
  logic [IW-1:0]  best_idx;
  logic           found;

  for (genvar g = 0; g < NCH; g++) begin : g_vtab
    assign vtab[g] = irq_vector(g, NCH);
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      elig[i] = pend_i[i] && !imask_i && (lvl_i[i*LW +: LW] > cur_lvl_i);
  end

  // Key = {level, vector}: the largest key is the highest level, ties by address
  always_comb begin
    best_key = '0;
    best_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i] && (!found || {lvl_i[i*LW +: LW], vtab[i]} > best_key)) begin
        found    = 1'b1;
        best_key = {lvl_i[i*LW +: LW], vtab[i]};
        best_idx = IW'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (found) grant_o[best_idx] = 1'b1;
  end

  assign valid_o = found;
  assign vec_o   = best_key[VW-1:0];

  // R10: at most one channel granted
  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  // R4: a grant goes only to a pending channel while maskables are enabled
  assert_grant_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |-> (((grant_o & ~pend_i) == '0) && !imask_i));
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int LW   = 3,
  parameter int NRST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRST-1:0]   rst_src_i,
  input  logic              nmi_req_i,
  input  logic              nmi_unblock_i,
  input  logic [NCH-1:0]    irq_pend_i,
  input  logic [NCH*LW-1:0] irq_lvl_i,
  input  logic              imask_i,
  input  logic [LW-1:0]     cur_lvl_i,
  input  logic              sw_trap_i,
  input  logic              sw_sys_i,
  input  logic              sw_swi_i,
  input  logic              boundary_i,
  output logic              take_o,
  output logic [15:0]       vec_o,
  output logic [NCH-1:0]    ack_o
);
  logic           nmi_live;
  logic           irq_valid;
  logic [NCH-1:0] irq_grant;
  logic [VW-1:0]  irq_vec;
  exc_cls_e       cls;
  logic [VW-1:0]  nvec;

  nmi_gate u_nmi (
    .clk(clk), .rst(rst), .unblock_i(nmi_unblock_i),
    .req_i(nmi_req_i), .req_o(nmi_live)
  );

  irq_select #(.NCH(NCH), .LW(LW)) u_irq (
    .clk(clk), .rst(rst), .pend_i(irq_pend_i), .lvl_i(irq_lvl_i),
    .imask_i(imask_i), .cur_lvl_i(cur_lvl_i),
    .valid_o(irq_valid), .grant_o(irq_grant), .vec_o(irq_vec)
  );

  always_comb begin
    cls  = CLS_NONE;
    nvec = '0;
    if (|rst_src_i) begin
      cls = CLS_RST; nvec = VEC_RESET;
    end else if (boundary_i) begin
      if (nmi_live) begin
        cls = CLS_NMI; nvec = VEC_NMI;
      end else if (irq_valid) begin
        cls = CLS_IRQ; nvec = irq_vec;
      end else if (sw_trap_i) begin
        cls = CLS_TRAP; nvec = VEC_TRAP;
      end else if (sw_sys_i) begin
        cls = CLS_SYS; nvec = VEC_SYS;
      end else if (sw_swi_i) begin
        cls = CLS_SWI; nvec = VEC_SWI;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      vec_o  <= '0;
      ack_o  <= '0;
    end else begin
      take_o <= (cls != CLS_NONE);
      if (cls != CLS_NONE) vec_o <= nvec;
      ack_o  <= (cls == CLS_IRQ) ? irq_grant : '0;
    end
  end

  // R1: any reset source gives the reset vector next cycle
  assert_reset_wins_R1: assert property (@(posedge clk) disable iff (rst)
    (|rst_src_i) |=> (take_o && vec_o == VEC_RESET));
  // R2: an unblocked NMI at a boundary beats maskable and software requests
  assert_nmi_rank_R2: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !(|rst_src_i) && nmi_live) |=> (take_o && vec_o == VEC_NMI));
  // R9: a take needs a boundary or a reset source one cycle before
  assert_take_needs_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i || (|rst_src_i)));
  // R10: an acknowledge is one-hot and comes with a take
  assert_ack_with_take_R10: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> (take_o && $onehot(ack_o)));
endmodule

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rst_src = '0;
  logic        nmi = 1'b0, unblk = 1'b0, imask = 1'b0;
  logic [7:0]  pend = '0;
  logic [23:0] lvl_flat;
  logic [2:0]  cur = '0;
  logic        trap = 1'b0, sys = 1'b0, swi = 1'b0, bnd = 1'b0;
  logic        take_o;
  logic [15:0] vec_o;
  logic [7:0]  ack_o;

  int lv [8];
  int total = 0, bad = 0;
  int m_block = 1, e_take = 0, e_vec = 0, e_ack = 0;
  string tag = "R11";

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < 8; c++) lvl_flat[c*3 +: 3] = 3'(lv[c]);

  exc_arbiter u0 (
    .clk(clk), .rst(rst), .rst_src_i(rst_src), .nmi_req_i(nmi),
    .nmi_unblock_i(unblk), .irq_pend_i(pend), .irq_lvl_i(lvl_flat),
    .imask_i(imask), .cur_lvl_i(cur), .sw_trap_i(trap), .sw_sys_i(sys),
    .sw_swi_i(swi), .boundary_i(bnd), .take_o(take_o), .vec_o(vec_o),
    .ack_o(ack_o)
  );

  function automatic int ref_vec(int c);
    return 'hFF80 + 2 * ((3 * c + 5) % 8);
  endfunction

  // Behavioural reference, evaluated on the inputs present at each edge
  always @(posedge clk) begin
    int hit, nv, bl, bv, bc;
    if (rst) begin
      e_take = 0; e_vec = 0; e_ack = 0; m_block = 1;
    end else begin
      hit = 0; nv = 0; e_ack = 0;
      if (rst_src != 0) begin hit = 1; nv = 'hFFFE; end
      else if (bnd) begin
        if (nmi && m_block == 0) begin hit = 1; nv = 'hFFF4; end
        else begin
          bl = -1; bv = -1; bc = -1;
          if (!imask)
            for (int c = 0; c < 8; c++)
              if (pend[c] && lv[c] > int'(cur) &&
                  (lv[c] > bl || (lv[c] == bl && ref_vec(c) > bv))) begin
                bl = lv[c]; bv = ref_vec(c); bc = c;
              end
          if (bc >= 0) begin hit = 1; nv = bv; e_ack = 1 << bc; end
          else if (trap) begin hit = 1; nv = 'hFFF8; end
          else if (sys)  begin hit = 1; nv = 'hFFF0; end
          else if (swi)  begin hit = 1; nv = 'hFFF6; end
        end
      end
      e_take = hit;
      if (hit != 0) e_vec = nv;
      if (unblk) m_block = 0;
    end
  end

  task automatic tick(input logic b);
    bnd = b;
    @(posedge clk);
    #2;
    total++;
    if (int'(take_o) != e_take || int'(vec_o) != e_vec || int'(ack_o) != e_ack) begin
      bad++;
      $display("FAIL %s: take=%0d vec=%h ack=%h expected take=%0d vec=%h ack=%h",
               tag, take_o, vec_o, ack_o, e_take, e_vec[15:0], e_ack[7:0]);
    end
    pend = pend & ~ack_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) lv[c] = 0;
    // R11: reset state
    tag = "R11"; rst = 1'b1;
    repeat (3) tick(1'b1);
    rst = 1'b0;
    repeat (2) tick(1'b0);

    // R9: no take without boundary; take one cycle after boundary
    tag = "R9";
    for (int c = 0; c < 8; c++) lv[c] = 2;
    pend = 8'h04;
    repeat (3) tick(1'b0);
    tick(1'b1);
    repeat (2) tick(1'b0);

    // R6: highest level first
    tag = "R6";
    lv[1] = 3; lv[2] = 6; lv[5] = 4;
    pend = 8'b0010_0110;
    repeat (4) tick(1'b1);

    // R7 and R10: all channels tie, serviced one per round by vector
    tag = "R7";
    for (int c = 0; c < 8; c++) lv[c] = 5;
    pend = 8'hFF;
    repeat (9) tick(1'b1);

    // R5: strict level comparison, level zero never competes
    tag = "R5";
    cur = 3'd5; lv[0] = 5; lv[1] = 6; lv[2] = 0;
    pend = 8'h07;
    repeat (3) tick(1'b1);
    cur = 3'd0;
    repeat (3) tick(1'b1);
    pend = '0;

    // R4: global mask blocks maskables; software still taken (R8)
    tag = "R4";
    for (int c = 0; c < 8; c++) lv[c] = 7;
    imask = 1'b1; pend = 8'hFF;
    repeat (3) tick(1'b1);
    tag = "R8"; swi = 1'b1;
    tick(1'b1);
    swi = 1'b0; imask = 1'b0; pend = '0;
    tick(1'b0);

    // R3: blocked NMI ignored, unblock, then taken; unblock is sticky
    tag = "R3"; nmi = 1'b1;
    repeat (2) tick(1'b1);
    unblk = 1'b1; tick(1'b0);
    unblk = 1'b0; tick(1'b1);
    nmi = 1'b0; tick(1'b0);
    nmi = 1'b1; tick(1'b1);
    nmi = 1'b0;

    // R2: NMI beats maskable and software; then maskable, then trap (R8)
    tag = "R2";
    nmi = 1'b1; pend = 8'h01; trap = 1'b1;
    tick(1'b1);
    nmi = 1'b0;
    tick(1'b1);
    tag = "R8";
    tick(1'b1);
    trap = 1'b0; sys = 1'b1; tick(1'b1);
    sys = 1'b0;  swi = 1'b1; tick(1'b1);
    swi = 1'b0;  tick(1'b1);

    // R1: reset source wins, even without a boundary
    tag = "R1";
    rst_src = 3'b100; nmi = 1'b1; pend = 8'h10; trap = 1'b1;
    tick(1'b0);
    rst_src = 3'b011; tick(1'b1);
    rst_src = '0; nmi = 1'b0; trap = 1'b0; pend = '0;
    tick(1'b0);

    // R10: random mix, losers stay pending until acknowledged
    tag = "R10";
    for (int n = 0; n < 400; n++) begin
      int s;
      for (int c = 0; c < 8; c++) lv[c] = $urandom_range(0, 7);
      cur   = 3'($urandom_range(0, 7));
      imask = ($urandom_range(0, 3) == 0);
      pend  = pend | 8'($urandom_range(0, 255) & $urandom_range(0, 255));
      rst_src = ($urandom_range(0, 39) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      nmi   = ($urandom_range(0, 15) == 0);
      unblk = ($urandom_range(0, 99) == 0);
      s = $urandom_range(0, 5);
      trap = (s == 1); sys = (s == 2); swi = (s == 3);
      tick(1'($urandom_range(0, 1)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule